// File: doc/BRIEF.md
# ADC Result Limit Watchdog

This block monitors the stream of conversion results coming out of an ADC sequencer and flags any result that falls outside software-programmed limits. It holds a small bank of limit sets. Each set carries a lower limit, an upper limit and a channel-select field, so each set is bound to exactly one channel. To move a set onto another channel, software rewrites that set's select field.

On every cycle that a conversion strobe is valid, the block compares the result against each set whose select field equals the strobe's channel number. A result strictly below the lower limit raises that set's low flag. A result strictly above the upper limit raises its high flag. When software programs the upper limit below the lower limit, a fixed priority applies: results under the lower limit raise only the low flag, and results over the lower limit raise only the high flag. Flags are sticky and are cleared by a write-one-to-clear. A per-flag mask selects which flags drive the single interrupt output.

Top module: `adc_wdog_top`

## Requirements
- R1: After reset, every limit register reads lower = 0 and upper = all ones (value 0x03FF0000 for a 10-bit result). Select, flag and mask registers read 0, `irq_o` is 0, and unmapped addresses read 0.
- R2: Register map, with N sets and word index s. Address 2s is the limit register of set s: lower limit in bits [RES_W-1:0] and upper limit in bits [16+RES_W-1:16]. Address 2s+1 is its select register, with the channel in bits [CH_W-1:0]. Address 2N is the flag register and address 2N+1 the mask register. In both, bit 2s is set s low and bit 2s+1 is set s high. Written values read back.
- R3: With lower <= upper, a matching result strictly below the lower limit sets the low flag, and a result strictly above the upper limit sets the high flag. Both flags are visible one clock edge after the strobe.
- R4: A result equal to either limit, or between them, sets no flag.
- R5: With upper < lower, a result below the lower limit sets only the low flag, a result above the lower limit sets only the high flag, and a result equal to the lower limit sets neither.
- R6: A strobe whose channel differs from a set's select field leaves that set's flags unchanged. Rewriting the select field moves the set to the new channel.
- R7: Flags are sticky. Later in-range results do not clear them.
- R8: Writing the flag register clears exactly the flag bits written as 1. Bits written as 0 are unchanged.
- R9: `irq_o` is high exactly when some flag bit and its mask bit are both 1.
- R10: If a violation and a clear of the same flag occur in the same cycle, the flag ends set.
- R11: Every set bound to the strobe's channel is evaluated independently in the same cycle.
- R12: With `conv_valid_i` low, no flag changes, whatever the channel and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_valid_i | input | 1 | Conversion-complete strobe |
| conv_ch_i | input | CH_W | Channel number of the result |
| conv_data_i | input | RES_W | Conversion result |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | clog2(2*N_SETS+2) | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| flags_o | output | 2*N_SETS | Sticky flags, bit 2s low, bit 2s+1 high |
| irq_o | output | 1 | Masked flag OR |

## Verification
A conversion strobe sampled at a clock edge shows up in the flag register and on `irq_o` immediately after that edge. A register write takes effect at the same edge. Reads are combinational on the address. The bench therefore drives all inputs at the falling edge, lets exactly one rising edge pass, and samples at the following falling edge, so every result is checked one edge after its stimulus. Full sweeps of all 1024 result codes and all 128 channels are compared against an arithmetic model of the limit rules.

// File: rtl/adc_wdog_pkg.sv
package adc_wdog_pkg;
  localparam int DATA_W = 32;
  localparam int UP_LSB = 16;

  typedef struct packed {
    logic lo;
    logic hi;
  } viol_t;
endpackage

// File: rtl/adc_wdog_cmp.sv
module adc_wdog_cmp
  import adc_wdog_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CH_W  = 7
) (
  input  logic             valid_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic [RES_W-1:0] data_i,
  input  logic [CH_W-1:0]  sel_i,
  input  logic [RES_W-1:0] lo_lim_i,
  input  logic [RES_W-1:0] up_lim_i,
  output viol_t            hit_o
);
  logic match, inverted, below_lo, above_lo, above_up;

  always_comb begin
    match    = valid_i && (ch_i == sel_i);
    inverted = up_lim_i < lo_lim_i;
    below_lo = data_i < lo_lim_i;
    above_lo = data_i > lo_lim_i;
    above_up = data_i > up_lim_i;
    hit_o.lo = match && below_lo;
    // inverted limits: lower limit splits low/high
    hit_o.hi = match && (inverted ? above_lo : above_up);
  end
endmodule

// File: rtl/adc_wdog_regs.sv
module adc_wdog_regs
  import adc_wdog_pkg::*;
#(
  parameter int N_SETS = 4,
  parameter int RES_W  = 10,
  parameter int CH_W   = 7,
  parameter int AW     = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [2*N_SETS-1:0]          flags_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [N_SETS-1:0][RES_W-1:0] lo_o,
  output logic [N_SETS-1:0][RES_W-1:0] up_o,
  output logic [N_SETS-1:0][CH_W-1:0]  sel_o,
  output logic [2*N_SETS-1:0]          mask_o,
  output logic [2*N_SETS-1:0]          clr_o
);
  localparam int NF        = 2 * N_SETS;
  localparam int FLAG_ADDR = NF;
  localparam int MASK_ADDR = NF + 1;

  logic flag_wr, mask_wr;
  assign flag_wr = wr_i && (addr_i == AW'(FLAG_ADDR));
  assign mask_wr = wr_i && (addr_i == AW'(MASK_ADDR));

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    logic lim_wr, sel_wr;
    assign lim_wr = wr_i && (addr_i == AW'(2 * s));
    assign sel_wr = wr_i && (addr_i == AW'(2 * s + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_o[s] <= '0;
        up_o[s] <= '1;
      end else if (lim_wr) begin
        lo_o[s] <= wdata_i[RES_W-1:0];
        up_o[s] <= wdata_i[UP_LSB+:RES_W];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_o[s] <= '0;
      else if (sel_wr) sel_o[s] <= wdata_i[CH_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else if (mask_wr) mask_o <= wdata_i[NF-1:0];
  end

  assign clr_o = flag_wr ? wdata_i[NF-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < N_SETS; s++) begin
      if (addr_i == AW'(2 * s)) begin
        rdata_o[RES_W-1:0]      = lo_o[s];
        rdata_o[UP_LSB+:RES_W]  = up_o[s];
      end
      if (addr_i == AW'(2 * s + 1)) rdata_o[CH_W-1:0] = sel_o[s];
    end
    if (addr_i == AW'(FLAG_ADDR)) rdata_o[NF-1:0] = flags_i;
    if (addr_i == AW'(MASK_ADDR)) rdata_o[NF-1:0] = mask_o;
  end
endmodule

// File: rtl/adc_wdog_flags.sv
module adc_wdog_flags
  import adc_wdog_pkg::*;
#(
  parameter int N_SETS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  viol_t [N_SETS-1:0]  hit_i,
  input  logic [2*N_SETS-1:0] clr_i,
  output logic [2*N_SETS-1:0] flags_o
);
  logic [2*N_SETS-1:0] set_vec;

  always_comb begin
    for (int s = 0; s < N_SETS; s++) begin
      set_vec[2*s]     = hit_i[s].lo;
      set_vec[2*s + 1] = hit_i[s].hi;
    end
  end

  // new events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else flags_o <= (flags_o & ~clr_i) | set_vec;
  end
endmodule

// File: rtl/adc_wdog_top.sv
module adc_wdog_top
  import adc_wdog_pkg::*;
#(
  parameter int N_SETS = 4,
  parameter int RES_W  = 10,
  parameter int CH_W   = 7
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              conv_valid_i,
  input  logic [CH_W-1:0]                   conv_ch_i,
  input  logic [RES_W-1:0]                  conv_data_i,
  input  logic                              reg_wr_i,
  input  logic [$clog2(2*N_SETS+2)-1:0]     reg_addr_i,
  input  logic [31:0]                       reg_wdata_i,
  output logic [31:0]                       reg_rdata_o,
  output logic [2*N_SETS-1:0]               flags_o,
  output logic                              irq_o
);
  localparam int AW = $clog2(2 * N_SETS + 2);

  logic [N_SETS-1:0][RES_W-1:0] lo_lim, up_lim;
  logic [N_SETS-1:0][CH_W-1:0]  ch_sel;
  logic [2*N_SETS-1:0]          mask_q, clr_vec, flags_q;
  viol_t [N_SETS-1:0]           hit;

  adc_wdog_regs #(
    .N_SETS(N_SETS), .RES_W(RES_W), .CH_W(CH_W), .AW(AW)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .flags_i (flags_q),
    .rdata_o (reg_rdata_o),
    .lo_o    (lo_lim),
    .up_o    (up_lim),
    .sel_o   (ch_sel),
    .mask_o  (mask_q),
    .clr_o   (clr_vec)
  );

  for (genvar s = 0; s < N_SETS; s++) begin : g_cmp
    adc_wdog_cmp #(.RES_W(RES_W), .CH_W(CH_W)) u_cmp (
      .valid_i  (conv_valid_i),
      .ch_i     (conv_ch_i),
      .data_i   (conv_data_i),
      .sel_i    (ch_sel[s]),
      .lo_lim_i (lo_lim[s]),
      .up_lim_i (up_lim[s]),
      .hit_o    (hit[s])
    );
  end

  adc_wdog_flags #(.N_SETS(N_SETS)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .clr_i   (clr_vec),
    .flags_o (flags_q)
  );

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & mask_q);
endmodule

// File: rtl/adc_wdog_chk.sv
module adc_wdog_chk #(
  parameter int N_SETS = 4,
  parameter int RES_W  = 10,
  parameter int CH_W   = 7,
  parameter int AW     = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         conv_valid_i,
  input logic [CH_W-1:0]              conv_ch_i,
  input logic [RES_W-1:0]             conv_data_i,
  input logic                         reg_wr_i,
  input logic [AW-1:0]                reg_addr_i,
  input logic [31:0]                  reg_wdata_i,
  input logic [2*N_SETS-1:0]          flags_q,
  input logic [N_SETS-1:0][RES_W-1:0] lo_lim,
  input logic [N_SETS-1:0][RES_W-1:0] up_lim,
  input logic [N_SETS-1:0][CH_W-1:0]  ch_sel,
  input logic                         irq_o
);
  localparam int NF = 2 * N_SETS;

  logic flag_wr;
  assign flag_wr = reg_wr_i && (reg_addr_i == AW'(NF));

  for (genvar b = 0; b < NF; b++) begin : g_bit
    p_rise_needs_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_q[b]) |-> $past(conv_valid_i));
    p_fall_needs_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flags_q[b]) |-> $past(flag_wr && reg_wdata_i[b]));
  end

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    p_low_sets_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_valid_i && conv_ch_i == ch_sel[s] && conv_data_i < lo_lim[s])
      |=> flags_q[2*s]);
    p_inverted_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_valid_i && conv_ch_i == ch_sel[s] && up_lim[s] < lo_lim[s]
       && conv_data_i > lo_lim[s]) |=> flags_q[2*s+1]);
    p_other_channel_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(conv_valid_i && conv_ch_i == ch_sel[s]) && !flag_wr)
      |=> $stable(flags_q[2*s+1:2*s]));
  end

  p_irq_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($countones(flags_q) > 0));
endmodule

bind adc_wdog_top adc_wdog_chk #(
  .N_SETS(N_SETS), .RES_W(RES_W), .CH_W(CH_W), .AW($clog2(2*N_SETS+2))
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_valid_i (conv_valid_i),
  .conv_ch_i    (conv_ch_i),
  .conv_data_i  (conv_data_i),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .flags_q      (flags_q),
  .lo_lim       (lo_lim),
  .up_lim       (up_lim),
  .ch_sel       (ch_sel),
  .irq_o        (irq_o)
);

// File: tb/adc_wdog_top_tb.sv
module adc_wdog_top_tb;
  localparam int N  = 4;
  localparam int RW = 10;
  localparam int CW = 7;
  localparam int AW = $clog2(2*N+2);
  localparam int FLAG_A = 2*N;
  localparam int MASK_A = 2*N + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cv = 1'b0;
  logic [CW-1:0] cch = '0;
  logic [RW-1:0] cdat = '0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [2*N-1:0] flags;
  logic          irq;

  int n_chk = 0, n_err = 0;
  int b_lo[N], b_up[N], b_sel[N];
  logic [2*N-1:0] b_mask = '0;

  always #2 clk = ~clk;

  adc_wdog_top #(.N_SETS(N), .RES_W(RW), .CH_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .conv_valid_i(cv), .conv_ch_i(cch), .conv_data_i(cdat),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .flags_o(flags), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [2*N-1:0] model(input int ch, input int d);
    logic [2*N-1:0] r = '0;
    for (int s = 0; s < N; s++) begin
      if (ch == b_sel[s]) begin
        if (d < b_lo[s]) r[2*s] = 1'b1;
        if (b_up[s] < b_lo[s]) begin
          if (d > b_lo[s]) r[2*s+1] = 1'b1;
        end else if (d > b_up[s]) r[2*s+1] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic wr_reg(input int a, input logic [31:0] v);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); wdata = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] v);
    addr = AW'(a);
    #0.5;
    v = rdata;
  endtask

  task automatic set_lim(input int s, input int lo, input int up);
    wr_reg(2*s, (32'(up) << 16) | 32'(lo));
    b_lo[s] = lo; b_up[s] = up;
  endtask

  task automatic set_sel(input int s, input int ch);
    wr_reg(2*s+1, 32'(ch));
    b_sel[s] = ch;
  endtask

  task automatic conv(input int ch, input int d);
    @(negedge clk);
    cv = 1'b1; cch = CW'(ch); cdat = RW'(d);
    @(negedge clk);
    cv = 1'b0;
  endtask

  task automatic clear_all();
    wr_reg(FLAG_A, 32'hFFFF_FFFF);
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [2*N-1:0] exp;
    for (int s = 0; s < N; s++) begin b_lo[s] = 0; b_up[s] = 1023; b_sel[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < N; s++) begin
      rd_reg(2*s, v);   chk("R1 limit reset", v, 32'h03FF_0000);
      rd_reg(2*s+1, v); chk("R1 select reset", v, 32'h0);
    end
    rd_reg(FLAG_A, v); chk("R1 flags reset", v, 32'h0);
    rd_reg(MASK_A, v); chk("R1 mask reset", v, 32'h0);
    rd_reg(15, v);     chk("R1 unmapped", v, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    // R2 configuration and readback
    set_lim(0, 300, 700); set_sel(0, 3);
    set_lim(1, 600, 200); set_sel(1, 3);
    set_lim(2, 0, 1023);  set_sel(2, 3);
    set_lim(3, 500, 500); set_sel(3, 9);
    for (int s = 0; s < N; s++) begin
      rd_reg(2*s, v);   chk("R2 limit readback", v, (32'(b_up[s]) << 16) | 32'(b_lo[s]));
      rd_reg(2*s+1, v); chk("R2 select readback", v, 32'(b_sel[s]));
    end

    // R12 strobe low: no effect
    @(negedge clk); cch = 3; cdat = 0; cv = 1'b0;
    @(negedge clk);
    rd_reg(FLAG_A, v); chk("R12 no strobe", v, 32'h0);

    // R3 R4 R5 R11 full result sweep on both bound channels
    for (int c = 0; c < 2; c++) begin
      for (int d = 0; d < 1024; d++) begin
        int ch = (c == 0) ? 3 : 9;
        conv(ch, d);
        rd_reg(FLAG_A, v);
        chk("R3/R4/R5/R11 sweep", v, 32'(model(ch, d)));
        clear_all();
      end
    end

    // R6 channel sweep
    for (int ch = 0; ch < 128; ch++) begin
      conv(ch, 1023);
      rd_reg(FLAG_A, v);
      chk("R6 channel sweep", v, 32'(model(ch, 1023)));
      clear_all();
    end
    // R6 rebind set 0 to channel 9
    set_sel(0, 9);
    conv(3, 100);
    rd_reg(FLAG_A, v); chk("R6 rebind old channel", v, 32'(model(3, 100)));
    clear_all();
    conv(9, 100);
    rd_reg(FLAG_A, v); chk("R6 rebind new channel", v, 32'(model(9, 100)));
    clear_all();
    set_sel(0, 3);

    // R7 sticky, R9 mask, R8 selective clear
    b_mask = 8'b0000_0010;
    wr_reg(MASK_A, 32'(b_mask));
    rd_reg(MASK_A, v); chk("R2 mask readback", v, 32'(b_mask));
    conv(3, 100);
    exp = model(3, 100);
    rd_reg(FLAG_A, v); chk("R9 flags before irq", v, 32'(exp));
    chk("R9 irq masked off", 32'(irq), 32'(|(exp & b_mask)));
    conv(3, 900);
    exp = exp | model(3, 900);
    rd_reg(FLAG_A, v); chk("R7 sticky accumulate", v, 32'(exp));
    chk("R9 irq raised", 32'(irq), 32'(|(exp & b_mask)));
    conv(3, 650);
    exp = exp | model(3, 650);
    rd_reg(FLAG_A, v); chk("R7 in-range keeps flags", v, 32'(exp));
    wr_reg(FLAG_A, 32'h2);
    exp = exp & ~8'h02;
    rd_reg(FLAG_A, v); chk("R8 clear one bit", v, 32'(exp));
    chk("R9 irq after clear", 32'(irq), 32'(|(exp & b_mask)));
    chk("R8 flags port", 32'(flags), 32'(exp));
    clear_all();
    rd_reg(FLAG_A, v); chk("R8 clear all", v, 32'h0);

    // R10 set beats clear in the same cycle
    @(negedge clk);
    cv = 1'b1; cch = 3; cdat = 100;
    wr = 1'b1; addr = AW'(FLAG_A); wdata = 32'hFF;
    @(negedge clk);
    cv = 1'b0; wr = 1'b0;
    rd_reg(FLAG_A, v); chk("R10 set wins", v, 32'(model(3, 100)));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule